// File: doc/BRIEF.md
# Bus Ownership Request Controller

This block lets a host take and give back the bus of an external 8-bit CPU. It drives the CPU's active-low bus request line and its reset line, and it watches the CPU's active-low bus acknowledge. The host sends one-hot commands. These commands move the block between four states. Each state joins two facts: whether the CPU is held in reset, and whether the host owns the bus. The address and strobe output drivers are enabled only while the host owns the bus. When they are enabled, the three strobes (memory request, read, write) idle high.

Each wait for acknowledge is bounded by a timeout. The timeout counts slow ticks, and the ticks are made from the clock by a parameterised divider. A reset pulse of fixed length comes from a cycle counter. While a wait or a pulse is in progress, the block reports busy and ignores new commands, except the reset command. The reset command aborts any operation in progress. The reset line's active level is not fixed. It is learned from the level seen on the reset pin in the first clock after the block leaves reset. The reset output driver stays off until that level has been captured.

Top module: `bus_grant_ctrl`

## Requirements
- R1: The block leaves reset in state 0 with bus request high, CPU reset active, and address/strobe drivers off with strobe values 0. Busy is high only in the first cycle. Whenever state 0 is reached with nothing in progress, CPU reset is active and bus request is high.
- R2: In the first clock after reset, the block samples `rst_sense_i` and sets `cpu_rst_oe_o`. From then on, active reset drives the sampled level and inactive reset drives its inverse.
- R3: Request (`cmd_i` bit 1) in state 0 lowers bus request and releases CPU reset. When acknowledge is seen low, the block enters state 1 with drivers on and strobes `3'b111`. Drivers are on only in states 1 or 3 while bus request is low.
- R4: If acknowledge stays high after a Request in state 0, the wait ends after exactly ACK_TICKS*TICK_DIV+1 busy cycles. CPU reset is then reasserted, bus request goes high, and the state stays 0.
- R5: Request in state 2 lowers bus request. On acknowledge the block enters state 3. On timeout, bus request goes high and the state stays 2.
- R6: Release (`cmd_i` bit 2) in state 1 turns the drivers off, asserts CPU reset, raises bus request and enters state 0. Release in state 3 turns the drivers off, raises bus request and enters state 2, with CPU reset left inactive.
- R7: Run (`cmd_i` bit 3) in state 0 releases CPU reset and enters state 2. Run in state 1 turns the drivers off and pulses CPU reset for PULSE_CYCLES cycles. It then turns the drivers back on and enters state 3.
- R8: Restart (`cmd_i` bit 4) in state 2 or 3 holds CPU reset active for exactly PULSE_CYCLES cycles. The state and the drivers are left unchanged.
- R9: M_Cycle (`cmd_i` bit 5) in state 3 turns the drivers off and raises bus request until acknowledge goes high, then requests the bus again. A fresh acknowledge restores the drivers in state 3. A timeout on the second wait raises bus request and enters state 2. A timeout on the first wait (acknowledge never released) restores the request and the drivers in state 3.
- R10: Reset (`cmd_i` bit 0) is accepted in every state, even while busy. In the next cycle the block is in state 0 and idle, with bus request high, CPU reset active and drivers off.
- R11: These commands have no effect on any output: a command not listed for the current state, a `cmd_i` value with more than one bit set, and any non-Reset command issued while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_i | input | 6 | One-hot command, held for one cycle: bit0 Reset, bit1 Request, bit2 Release, bit3 Run, bit4 Restart, bit5 M_Cycle |
| rst_sense_i | input | 1 | Level seen on the CPU reset pin before the block drives it |
| busack_n_i | input | 1 | CPU bus acknowledge, active low |
| busreq_n_o | output | 1 | CPU bus request, active low |
| cpu_rst_o | output | 1 | CPU reset level |
| cpu_rst_oe_o | output | 1 | Output enable for the CPU reset driver |
| bus_oe_o | output | 1 | Output enable for the address and strobe drivers |
| strobe_n_o | output | 3 | Strobe values {write, read, memory request}: all high while enabled, 0 while floated |
| state_o | output | 2 | 0 reset, 1 reset and bus held, 2 running, 3 running and bus held |
| acquired_o | output | 1 | High in states 1 and 3 |
| busy_o | output | 1 | High while polarity capture, an acknowledge wait or a reset pulse is in progress |

## Verification
A wrong internal state shows up one cycle later at the ports. It can show as a state code that disagrees with the bus request and reset lines, or as drivers enabled while the request is high. A bad phase is found the same way: busy stays high too long or drops too early, or the reset line is released before its pulse length has elapsed. A wrong timer setting appears as a timeout at the wrong cycle. The bench checks every output on every clock against a behavioural model, so any of these errors is found in the first cycle it reaches a port. Long timeouts and pulses are measured as exact busy-cycle counts.

// File: rtl/bgc_pkg.sv
package bgc_pkg;

  localparam int CMD_W       = 6;
  localparam int CMD_RESET   = 0;
  localparam int CMD_REQUEST = 1;
  localparam int CMD_RELEASE = 2;
  localparam int CMD_RUN     = 3;
  localparam int CMD_RESTART = 4;
  localparam int CMD_MCYCLE  = 5;

  // bit 0 of the state code marks bus ownership
  typedef enum logic [1:0] {
    ST_RESET      = 2'd0,
    ST_RESET_HELD = 2'd1,
    ST_RUN        = 2'd2,
    ST_RUN_HELD   = 2'd3
  } bus_state_e;

  typedef enum logic [1:0] {
    PH_IDLE     = 2'd0,
    PH_ACK_WAIT = 2'd1,
    PH_PULSE    = 2'd2,
    PH_REL_WAIT = 2'd3
  } phase_e;

  typedef enum logic [2:0] {
    OP_FROM_RESET = 3'd0,
    OP_FROM_RUN   = 3'd1,
    OP_MCYCLE     = 3'd2,
    OP_RUN_HELD   = 3'd3,
    OP_RESTART    = 3'd4
  } op_e;

endpackage

// File: rtl/bgc_tick_gen.sv
module bgc_tick_gen #(
  parameter int TICK_DIV = 12_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  output logic tick_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRES_MAX = PW'(TICK_DIV - 1);

  logic [PW-1:0] pres_q, pres_d;

  always_comb begin
    pres_d = pres_q;
    if (clear_i)               pres_d = '0;
    else if (pres_q == PRES_MAX) pres_d = '0;
    else                       pres_d = pres_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pres_q <= '0;
    else        pres_q <= pres_d;
  end

  assign tick_o = (pres_q == PRES_MAX);

  p_pres_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pres_q <= PRES_MAX);

endmodule

// File: rtl/bgc_wait_timer.sv
module bgc_wait_timer #(
  parameter int ACK_TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int CW = $clog2(ACK_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(ACK_TICKS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = tick_i && (cnt_q != LIMIT);

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)     cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= LIMIT;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == LIMIT);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

  p_start_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !expired_o);

endmodule

// File: rtl/bgc_pulse_timer.sv
module bgc_pulse_timer #(
  parameter int PULSE_CYCLES = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic done_o
);
  localparam int PCW = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
  localparam logic [PCW-1:0] LAST = PCW'(PULSE_CYCLES - 1);

  logic [PCW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)           cnt_d = '0;
    else if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= LAST;
    else        cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == LAST);

  p_pulse_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/bus_grant_ctrl.sv
module bus_grant_ctrl
  import bgc_pkg::*;
#(
  parameter int TICK_DIV     = 12_500_000,
  parameter int ACK_TICKS    = 20,
  parameter int PULSE_CYCLES = 1250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             rst_sense_i,
  input  logic             busack_n_i,
  output logic             busreq_n_o,
  output logic             cpu_rst_o,
  output logic             cpu_rst_oe_o,
  output logic             bus_oe_o,
  output logic [2:0]       strobe_n_o,
  output logic [1:0]       state_o,
  output logic             acquired_o,
  output logic             busy_o
);

  bus_state_e st_q, st_d;
  phase_e     ph_q, ph_d;
  op_e        op_q, op_d;
  logic       req_n_q, req_n_d;
  logic       ract_q, ract_d;
  logic       oe_q, oe_d;
  logic       pol_q, pol_valid_q;
  logic       wait_go, pulse_go;
  logic       tick, wait_expired, pulse_done;
  logic       cmd_valid, cmd_reset;

  bgc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clear_i(wait_go), .tick_o(tick));

  bgc_wait_timer #(.ACK_TICKS(ACK_TICKS)) u_wait (
    .clk(clk), .rst_n(rst_n), .start_i(wait_go), .tick_i(tick),
    .expired_o(wait_expired));

  bgc_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start_i(pulse_go), .done_o(pulse_done));

  assign cmd_valid = pol_valid_q && $onehot(cmd_i);
  assign cmd_reset = cmd_valid && cmd_i[CMD_RESET];

  // polarity capture: one clock after reset release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q       <= 1'b0;
      pol_valid_q <= 1'b0;
    end else if (!pol_valid_q) begin
      pol_q       <= rst_sense_i;
      pol_valid_q <= 1'b1;
    end
  end

  always_comb begin
    st_d     = st_q;
    ph_d     = ph_q;
    op_d     = op_q;
    req_n_d  = req_n_q;
    ract_d   = ract_q;
    oe_d     = oe_q;
    wait_go  = 1'b0;
    pulse_go = 1'b0;
    if (cmd_reset) begin
      st_d    = ST_RESET;
      ph_d    = PH_IDLE;
      req_n_d = 1'b1;
      ract_d  = 1'b1;
      oe_d    = 1'b0;
    end else if (ph_q == PH_IDLE) begin
      if (cmd_valid && cmd_i[CMD_REQUEST]) begin
        if (st_q == ST_RESET) begin
          req_n_d = 1'b0;
          ract_d  = 1'b0;
          ph_d    = PH_ACK_WAIT;
          op_d    = OP_FROM_RESET;
          wait_go = 1'b1;
        end else if (st_q == ST_RUN) begin
          req_n_d = 1'b0;
          ph_d    = PH_ACK_WAIT;
          op_d    = OP_FROM_RUN;
          wait_go = 1'b1;
        end
      end else if (cmd_valid && cmd_i[CMD_RELEASE]) begin
        if (st_q == ST_RESET_HELD) begin
          oe_d    = 1'b0;
          ract_d  = 1'b1;
          req_n_d = 1'b1;
          st_d    = ST_RESET;
        end else if (st_q == ST_RUN_HELD) begin
          oe_d    = 1'b0;
          req_n_d = 1'b1;
          st_d    = ST_RUN;
        end
      end else if (cmd_valid && cmd_i[CMD_RUN]) begin
        if (st_q == ST_RESET) begin
          ract_d = 1'b0;
          st_d   = ST_RUN;
        end else if (st_q == ST_RESET_HELD) begin
          oe_d     = 1'b0;
          ract_d   = 1'b1;
          ph_d     = PH_PULSE;
          op_d     = OP_RUN_HELD;
          pulse_go = 1'b1;
        end
      end else if (cmd_valid && cmd_i[CMD_RESTART]) begin
        if (st_q == ST_RUN || st_q == ST_RUN_HELD) begin
          ract_d   = 1'b1;
          ph_d     = PH_PULSE;
          op_d     = OP_RESTART;
          pulse_go = 1'b1;
        end
      end else if (cmd_valid && cmd_i[CMD_MCYCLE]) begin
        if (st_q == ST_RUN_HELD) begin
          oe_d    = 1'b0;
          req_n_d = 1'b1;
          ph_d    = PH_REL_WAIT;
          op_d    = OP_MCYCLE;
          wait_go = 1'b1;
        end
      end
    end else begin
      unique case (ph_q)
        PH_ACK_WAIT: begin
          if (!busack_n_i) begin
            ph_d = PH_IDLE;
            oe_d = 1'b1;
            if (op_q == OP_FROM_RESET)    st_d = ST_RESET_HELD;
            else if (op_q == OP_FROM_RUN) st_d = ST_RUN_HELD;
          end else if (wait_expired) begin
            ph_d    = PH_IDLE;
            req_n_d = 1'b1;
            if (op_q == OP_FROM_RESET) ract_d = 1'b1;
            if (op_q == OP_MCYCLE)     st_d   = ST_RUN;
          end
        end
        PH_PULSE: begin
          if (pulse_done) begin
            ph_d   = PH_IDLE;
            ract_d = 1'b0;
            if (op_q == OP_RUN_HELD) begin
              oe_d = 1'b1;
              st_d = ST_RUN_HELD;
            end
          end
        end
        PH_REL_WAIT: begin
          if (busack_n_i) begin
            req_n_d = 1'b0;
            ph_d    = PH_ACK_WAIT;
            wait_go = 1'b1;
          end else if (wait_expired) begin
            req_n_d = 1'b0;
            oe_d    = 1'b1;
            ph_d    = PH_IDLE;
          end
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RESET;
      ph_q    <= PH_IDLE;
      op_q    <= OP_FROM_RESET;
      req_n_q <= 1'b1;
      ract_q  <= 1'b1;
      oe_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      ph_q    <= ph_d;
      op_q    <= op_d;
      req_n_q <= req_n_d;
      ract_q  <= ract_d;
      oe_q    <= oe_d;
    end
  end

  assign busreq_n_o   = req_n_q;
  assign cpu_rst_o    = ract_q ? pol_q : ~pol_q;
  assign cpu_rst_oe_o = pol_valid_q;
  assign bus_oe_o     = oe_q;
  assign strobe_n_o   = oe_q ? 3'b111 : 3'b000;
  assign state_o      = st_q;
  assign acquired_o   = st_q[0];
  assign busy_o       = !pol_valid_q || (ph_q != PH_IDLE);

  p_oe_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> st_q[0]);

  p_oe_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> !req_n_q);

  p_pulse_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_PULSE) |-> ract_q);

  p_idle_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && st_q == ST_RESET) |-> (ract_q && req_n_q));

  p_reset_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_valid_q && cmd_i == 6'b000001) |=>
      (st_q == ST_RESET && ph_q == PH_IDLE && req_n_q && ract_q && !oe_q));

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && cmd_i == '0) |=>
      ($stable(st_q) && $stable(oe_q) && $stable(req_n_q) && $stable(ract_q)));

endmodule

// File: tb/bus_grant_ctrl_bench.sv
`timescale 1ns/1ps
module bus_grant_ctrl_bench;
  localparam int DIV = 4;
  localparam int ACK = 5;
  localparam int PL  = 6;
  localparam int TO  = ACK * DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] cmd_i = '0;
  logic       rst_sense_i = 1'b1;
  logic       busack_n_i = 1'b1;
  logic       busreq_n_o, cpu_rst_o, cpu_rst_oe_o, bus_oe_o, acquired_o, busy_o;
  logic [2:0] strobe_n_o;
  logic [1:0] state_o;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  bus_grant_ctrl #(.TICK_DIV(DIV), .ACK_TICKS(ACK), .PULSE_CYCLES(PL)) u_bus_grant_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .rst_sense_i(rst_sense_i),
    .busack_n_i(busack_n_i), .busreq_n_o(busreq_n_o), .cpu_rst_o(cpu_rst_o),
    .cpu_rst_oe_o(cpu_rst_oe_o), .bus_oe_o(bus_oe_o), .strobe_n_o(strobe_n_o),
    .state_o(state_o), .acquired_o(acquired_o), .busy_o(busy_o));

  always #4 clk = ~clk;

  // CPU acknowledge model
  int ack_delay = 3;
  bit ack_hold = 0;
  int lowcnt = 0;
  always @(negedge clk) begin
    if (rst_n && !busreq_n_o) begin
      lowcnt++;
      if (ack_delay >= 0 && lowcnt >= ack_delay) busack_n_i = 1'b0;
    end else begin
      lowcnt = 0;
      if (!ack_hold) busack_n_i = 1'b1;
    end
  end

  // behavioural reference model
  bit [1:0] m_st;
  int m_ph, m_op, m_k;
  bit m_req, m_ract, m_oe, m_pv, m_pol;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_ph = 0; m_op = 0; m_k = 0;
      m_req = 1; m_ract = 1; m_oe = 0; m_pv = 0; m_pol = 0;
    end else if (!m_pv) begin
      m_pv = 1; m_pol = rst_sense_i;
    end else if (cmd_i == 6'b000001) begin
      m_st = 0; m_ph = 0; m_req = 1; m_ract = 1; m_oe = 0;
    end else if (m_ph == 0) begin
      if ($countones(cmd_i) == 1) begin
        if (cmd_i[1] && (m_st == 0 || m_st == 2)) begin
          m_req = 0; if (m_st == 0) m_ract = 0;
          m_op = (m_st == 0) ? 0 : 1; m_ph = 1; m_k = 0;
        end else if (cmd_i[2] && m_st == 1) begin
          m_oe = 0; m_ract = 1; m_req = 1; m_st = 0;
        end else if (cmd_i[2] && m_st == 3) begin
          m_oe = 0; m_req = 1; m_st = 2;
        end else if (cmd_i[3] && m_st == 0) begin
          m_ract = 0; m_st = 2;
        end else if (cmd_i[3] && m_st == 1) begin
          m_oe = 0; m_ract = 1; m_ph = 2; m_op = 3; m_k = 0;
        end else if (cmd_i[4] && m_st[1]) begin
          m_ract = 1; m_ph = 2; m_op = 4; m_k = 0;
        end else if (cmd_i[5] && m_st == 3) begin
          m_oe = 0; m_req = 1; m_ph = 3; m_op = 2; m_k = 0;
        end
      end
    end else begin
      m_k++;
      if (m_ph == 1) begin
        if (!busack_n_i) begin
          m_ph = 0; m_oe = 1;
          if (m_op == 0) m_st = 1; else if (m_op == 1) m_st = 3;
        end else if (m_k > TO) begin
          m_ph = 0; m_req = 1;
          if (m_op == 0) m_ract = 1;
          if (m_op == 2) m_st = 2;
        end
      end else if (m_ph == 2) begin
        if (m_k == PL) begin
          m_ph = 0; m_ract = 0;
          if (m_op == 3) begin m_oe = 1; m_st = 3; end
        end
      end else begin
        if (busack_n_i) begin
          m_req = 0; m_ph = 1; m_k = 0;
        end else if (m_k > TO) begin
          m_req = 0; m_oe = 1; m_ph = 0;
        end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [10:0] act, exp;
      act = {busreq_n_o, cpu_rst_o, cpu_rst_oe_o, bus_oe_o, strobe_n_o, state_o, acquired_o, busy_o};
      exp = {m_req, (m_ract ? m_pol : !m_pol), m_pv, m_oe, (m_oe ? 3'b111 : 3'b000),
             m_st, m_st[0], (!m_pv || m_ph != 0)};
      checks++;
      if (act !== exp) begin
        errors++;
        $display("FAIL %s cycle compare: actual=%b expected=%b at %0t", cur_req, act, exp, $time);
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [5:0] c);
    @(negedge clk); cmd_i = c;
    @(negedge clk); cmd_i = '0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_o && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic do_reset(input logic sense);
    rst_n = 1'b0; rst_sense_i = sense;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    cur_req = "R1";
    do_reset(1'b1);
    chk("R1", "state after reset", state_o, 0);
    chk("R1", "busreq", busreq_n_o, 1);
    chk("R1", "strobes", strobe_n_o, 0);
    chk("R2", "reset level active-high", cpu_rst_o, 1);
    chk("R2", "reset oe", cpu_rst_oe_o, 1);

    cur_req = "R3"; ack_delay = 3;
    issue(6'b000010); wait_idle(n);
    chk("R3", "state", state_o, 1);
    chk("R3", "strobes", strobe_n_o, 7);
    chk("R3", "reset released", cpu_rst_o, 0);

    cur_req = "R6";
    issue(6'b000100); @(negedge clk);
    chk("R6", "state", state_o, 0);
    chk("R6", "reset", cpu_rst_o, 1);

    cur_req = "R4"; ack_delay = -1;
    issue(6'b000010); wait_idle(n);
    chk("R4", "busy cycles", n, TO + 1);
    chk("R4", "state", state_o, 0);
    chk("R4", "reset", cpu_rst_o, 1);
    chk("R4", "busreq", busreq_n_o, 1);

    cur_req = "R7";
    issue(6'b001000); @(negedge clk);
    chk("R7", "run state", state_o, 2);
    chk("R7", "reset", cpu_rst_o, 0);

    cur_req = "R5";
    issue(6'b000010); wait_idle(n);
    chk("R5", "timeout state", state_o, 2);
    chk("R5", "busreq", busreq_n_o, 1);
    ack_delay = 2;
    issue(6'b000010); wait_idle(n);
    chk("R5", "held state", state_o, 3);

    cur_req = "R8";
    issue(6'b010000); wait_idle(n);
    chk("R8", "pulse length", n, PL);
    chk("R8", "state", state_o, 3);
    chk("R8", "oe", bus_oe_o, 1);

    cur_req = "R9";
    issue(6'b100000); wait_idle(n);
    chk("R9", "mcycle state", state_o, 3);
    chk("R9", "mcycle oe", bus_oe_o, 1);
    ack_delay = -1;
    issue(6'b100000); wait_idle(n);
    chk("R9", "lost bus state", state_o, 2);
    chk("R9", "busreq", busreq_n_o, 1);
    ack_delay = 2;
    issue(6'b000010); wait_idle(n);
    ack_hold = 1;
    issue(6'b100000); wait_idle(n);
    chk("R9", "stuck ack state", state_o, 3);
    chk("R9", "stuck ack oe", bus_oe_o, 1);
    ack_hold = 0;

    cur_req = "R6";
    issue(6'b000100); @(negedge clk);
    chk("R6", "release held run", state_o, 2);
    chk("R6", "reset inactive", cpu_rst_o, 0);

    cur_req = "R11";
    issue(6'b000100); issue(6'b100000); issue(6'b001000); issue(6'b000011);
    @(negedge clk);
    chk("R11", "ignored state", state_o, 2);
    chk("R11", "ignored busreq", busreq_n_o, 1);

    cur_req = "R10";
    issue(6'b000001); @(negedge clk);
    chk("R10", "reset cmd state", state_o, 0);
    chk("R10", "reset cmd level", cpu_rst_o, 1);

    cur_req = "R7";
    issue(6'b000010); wait_idle(n);
    issue(6'b001000); wait_idle(n);
    chk("R7", "run held state", state_o, 3);
    chk("R7", "run held oe", bus_oe_o, 1);
    chk("R7", "run held reset", cpu_rst_o, 0);

    cur_req = "R11";
    issue(6'b010000); issue(6'b000100); wait_idle(n);
    chk("R11", "busy ignores release", state_o, 3);

    cur_req = "R10";
    issue(6'b000100); ack_delay = -1;
    issue(6'b000010); repeat (3) @(negedge clk);
    issue(6'b000001);
    chk("R10", "abort state", state_o, 0);
    chk("R10", "abort busy", busy_o, 0);
    chk("R10", "abort busreq", busreq_n_o, 1);

    cur_req = "R2";
    do_reset(1'b0);
    chk("R2", "reset level active-low", cpu_rst_o, 0);
    issue(6'b001000); @(negedge clk);
    chk("R2", "released level", cpu_rst_o, 1);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule